// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit core and a word-addressed, big-endian data memory. It forms the effective address by adding a sign-extended offset to a base register value. It presents the word address to the memory, and it flags any access whose size does not fit the low address bits.

For stores, the low-order bits of the source register are copied onto every lane that the access size can reach. A per-lane write enable then picks the lanes that are actually written. For loads, the memory returns the whole word one cycle after the read strobe. The unit then selects the addressed byte or halfword in big-endian order and widens it to 32 bits, either with the sign bit or with zeros.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `base + sign_extend(offset)`, and `mem_addr` carries its bits 31..2.
- R2: A signed byte load (`req_size`=00, `req_unsigned`=0) returns the addressed byte in bits 7..0 and copies its bit 7 into bits 31..8.
- R3: An unsigned byte load (`req_size`=00, `req_unsigned`=1) returns the addressed byte in bits 7..0 with bits 31..8 all zero.
- R4: A halfword load (`req_size`=01) at address A places the byte at A in bits 15..8 and the byte at A+1 in bits 7..0. The upper 16 bits are filled with bit 15 when signed and with zeros when unsigned.
- R5: A word load (`req_size`=10) returns all 32 bits of the memory word unchanged.
- R6: The store data is the source bits 7..0 repeated four times for a byte, the source bits 15..0 repeated twice for a halfword, and the whole source word for a word store.
- R7: Lanes are big-endian: byte offset 0 is data bits 31..24 and is enabled by `mem_be[3]`, and offset k is enabled by `mem_be[3-k]`. A halfword at offset 0 enables 1100, one at offset 2 enables 0011, and a word enables 1111. `mem_be` is 0000 whenever `mem_wr` is low.
- R8: `align_err` is raised with a valid request when the address is misaligned for the access size. A halfword is misaligned when address bit 0 is set. A word is misaligned when address bits 1..0 are non-zero. Size code 11 always raises the flag. A flagged request drives neither `mem_wr` nor `mem_rd`.
- R9: `ld_valid` is high in the cycle after an accepted load, and in that cycle `ld_data` holds the extracted value. In any other cycle `ld_data` is zero.
- R10: After reset, `ld_valid` is low until a load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| req_unsigned | input | 1 | Zero-extend loaded byte/halfword |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed address offset |
| wr_src | input | 32 | Store source register value |
| mem_addr | output | 30 | Word address to memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_be | output | 4 | Per-lane write enables, bit 3 = bits 31..24 |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Word returned one cycle after mem_rd |
| align_err | output | 1 | Misaligned access flag |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted and extended load value |

## Verification
The hardest case to reach is a sub-word load that reads a lane an earlier store has just changed. The sign bit of that lane must be set, and the neighbouring lanes must carry different values, so that a wrong lane or the wrong extension shows up. The stimulus addresses a window of only sixteen memory words and offsets the base by small signed values, so random stores and loads keep meeting on the same words with every lane and size. The memory is seeded with bytes whose top bit varies. Directed cases add offsets that cross zero, along with each misaligned form.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic             req_unsigned,
  input  logic [31:0]      base,
  input  logic [OFS_W-1:0] offset,
  input  logic [31:0]      wr_src,
  output logic [29:0]      mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             align_err,
  output logic             ld_valid,
  output logic [31:0]      ld_data
);
  localparam logic [1:0] SZ_B = 2'b00;
  localparam logic [1:0] SZ_H = 2'b01;
  localparam logic [1:0] SZ_W = 2'b10;
  localparam int EXT_W = 32 - OFS_W;

  logic [31:0] ea;
  logic [1:0]  lane;
  logic        mis;
  logic        go;
  logic [3:0]  be_sel;

  assign ea       = base + {{EXT_W{offset[OFS_W-1]}}, offset};
  assign lane     = ea[1:0];
  assign mem_addr = ea[31:2];

  always_comb begin
    case (req_size)
      SZ_B:    mis = 1'b0;
      SZ_H:    mis = lane[0];
      SZ_W:    mis = |lane;
      default: mis = 1'b1;
    endcase
  end

  assign go        = req_valid & ~mis;
  assign align_err = req_valid & mis;
  assign mem_wr    = go & req_write;
  assign mem_rd    = go & ~req_write;

  always_comb begin
    case (req_size)
      SZ_B:    be_sel = 4'b1000 >> lane;
      SZ_H:    be_sel = lane[1] ? 4'b0011 : 4'b1100;
      SZ_W:    be_sel = 4'b1111;
      default: be_sel = 4'b0000;
    endcase
  end
  assign mem_be = mem_wr ? be_sel : 4'b0000;

  always_comb begin
    case (req_size)
      SZ_B:    mem_wdata = {4{wr_src[7:0]}};
      SZ_H:    mem_wdata = {2{wr_src[15:0]}};
      default: mem_wdata = wr_src;
    endcase
  end

  logic       ld_valid_q;
  logic [1:0] ld_lane_q;
  logic [1:0] ld_size_q;
  logic       ld_uns_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid_q <= 1'b0;
      ld_lane_q  <= 2'b00;
      ld_size_q  <= SZ_W;
      ld_uns_q   <= 1'b0;
    end else begin
      ld_valid_q <= mem_rd;
      if (mem_rd) begin
        ld_lane_q <= lane;
        ld_size_q <= req_size;
        ld_uns_q  <= req_unsigned;
      end
    end
  end

  logic [7:0]  byte_v;
  logic [15:0] half_v;
  logic [31:0] shifted;

  assign shifted = mem_rdata << {ld_lane_q, 3'b000};
  assign byte_v  = shifted[31:24];
  assign half_v  = shifted[31:16];
  assign ld_valid = ld_valid_q;

  always_comb begin
    if (!ld_valid_q) ld_data = 32'h0;
    else begin
      case (ld_size_q)
        SZ_B:    ld_data = {{24{byte_v[7] & ~ld_uns_q}}, byte_v};
        SZ_H:    ld_data = {{16{half_v[15] & ~ld_uns_q}}, half_v};
        default: ld_data = mem_rdata;
      endcase
    end
  end

  // R7
  be_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_be != 4'b0000);
  // R7
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && req_size == SZ_B) |-> $countones(mem_be) == 1);
  // R7
  half_two_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && req_size == SZ_H) |-> $countones(mem_be) == 2);
  // R8
  err_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !mem_wr && !mem_rd);
  // R9
  load_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ld_valid);
  // R9
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> ld_data == 32'h0);
endmodule

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_unsigned = 0;
  logic [1:0] req_size = 0;
  logic [31:0] base = 0, wr_src = 0;
  logic [15:0] offset = 0;
  logic [29:0] mem_addr;
  logic mem_rd, mem_wr, align_err, ld_valid;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, ld_data;
  logic [31:0] mem_rdata = 0;

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [16];
  logic [31:0] shadow [16];

  always #2.5 clk = ~clk;

  lsu_lane_align u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_unsigned(req_unsigned), .base(base),
    .offset(offset), .wr_src(wr_src), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .align_err(align_err), .ld_valid(ld_valid),
    .ld_data(ld_data));

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[3:0]];
    if (mem_wr) begin
      if (mem_be[3]) mem[mem_addr[3:0]][31:24] <= mem_wdata[31:24];
      if (mem_be[2]) mem[mem_addr[3:0]][23:16] <= mem_wdata[23:16];
      if (mem_be[1]) mem[mem_addr[3:0]][15:8]  <= mem_wdata[15:8];
      if (mem_be[0]) mem[mem_addr[3:0]][7:0]   <= mem_wdata[7:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic e_mis(input logic [1:0] sz, input logic [1:0] ln);
    if (sz == 2'b00) return 1'b0;
    if (sz == 2'b01) return ln[0];
    if (sz == 2'b10) return ln != 2'b00;
    return 1'b1;
  endfunction

  function automatic logic [3:0] e_be(input logic [1:0] sz, input logic [1:0] ln);
    if (sz == 2'b00) return ln == 0 ? 4'b1000 : ln == 1 ? 4'b0100 : ln == 2 ? 4'b0010 : 4'b0001;
    if (sz == 2'b01) return ln == 0 ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] e_wd(input logic [1:0] sz, input logic [31:0] s);
    if (sz == 2'b00) return {s[7:0], s[7:0], s[7:0], s[7:0]};
    if (sz == 2'b01) return {s[15:0], s[15:0]};
    return s;
  endfunction

  function automatic logic [31:0] e_ld(input logic [31:0] w, input logic [1:0] sz,
                                       input logic [1:0] ln, input logic u);
    logic [7:0] b [4];
    logic [15:0] h;
    b[0] = w[31:24]; b[1] = w[23:16]; b[2] = w[15:8]; b[3] = w[7:0];
    if (sz == 2'b00) return u ? {24'h0, b[ln]} : {{24{b[ln][7]}}, b[ln]};
    if (sz == 2'b01) begin
      h = {b[ln], b[ln + 2'd1]};
      return u ? {16'h0, h} : {{16{h[15]}}, h};
    end
    return w;
  endfunction

  task automatic access(input logic wr, input logic [1:0] sz, input logic u,
                        input logic [31:0] b, input logic [15:0] o, input logic [31:0] s);
    logic [31:0] ea;
    logic m;
    logic [3:0] be;
    logic [31:0] wd, exp_ld;
    ea = b + {{16{o[15]}}, o};
    m = e_mis(sz, ea[1:0]);
    req_valid = 1; req_write = wr; req_size = sz; req_unsigned = u;
    base = b; offset = o; wr_src = s;
    #1;
    chk("R1 addr", {2'b0, mem_addr}, {2'b0, ea[31:2]});
    chk("R8 err", {31'b0, align_err}, {31'b0, m});
    chk("R8 rd", {30'b0, mem_wr, mem_rd}, m ? 32'h0 : (wr ? 32'h2 : 32'h1));
    if (wr) begin
      chk("R7 be", {28'b0, mem_be}, m ? 32'h0 : {28'b0, e_be(sz, ea[1:0])});
      if (!m) begin
        chk("R6 wdata", mem_wdata, e_wd(sz, s));
        be = e_be(sz, ea[1:0]); wd = e_wd(sz, s);
        if (be[3]) shadow[ea[5:2]][31:24] = wd[31:24];
        if (be[2]) shadow[ea[5:2]][23:16] = wd[23:16];
        if (be[1]) shadow[ea[5:2]][15:8]  = wd[15:8];
        if (be[0]) shadow[ea[5:2]][7:0]   = wd[7:0];
      end
    end else chk("R7 be idle", {28'b0, mem_be}, 32'h0);
    exp_ld = e_ld(shadow[ea[5:2]], sz, ea[1:0], u);
    @(negedge clk);
    req_valid = 0;
    #1;
    if (!wr && !m) begin
      chk("R9 ld_valid", {31'b0, ld_valid}, 32'h1);
      chk(sz == 2'b00 ? (u ? "R3 ubyte" : "R2 sbyte") : sz == 2'b01 ? "R4 half" : "R5 word",
          ld_data, exp_ld);
    end else begin
      chk("R9 no ld_valid", {31'b0, ld_valid}, 32'h0);
      chk("R9 ld_data zero", ld_data, 32'h0);
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = {8'h80 + 8'(i), 8'h11 * 8'(i), 8'hF0 - 8'(i), 8'h7F - 8'(i)};
      shadow[i] = mem[i];
    end
    void'($urandom(32'd2024));
    #12;
    @(negedge clk);
    // R10 reset state
    chk("R10 ld_valid reset", {31'b0, ld_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ld_valid after reset", {31'b0, ld_valid}, 32'h0);
    // directed
    access(0, 2'b00, 0, 32'h100, 16'h0000, 0);
    access(0, 2'b00, 1, 32'h100, 16'h0000, 0);
    access(1, 2'b00, 0, 32'h105, 16'hFFFF, 32'h1234_56A5);
    access(0, 2'b00, 0, 32'h104, 16'h0000, 0);
    access(0, 2'b01, 0, 32'h108, 16'h0002, 0);
    access(0, 2'b01, 1, 32'h108, 16'h0002, 0);
    access(1, 2'b01, 0, 32'h10C, 16'h0000, 32'hDEAD_BEEF);
    access(0, 2'b01, 0, 32'h10C, 16'h0000, 0);
    access(1, 2'b10, 0, 32'h120, 16'hFFF0, 32'hCAFE_F00D);
    access(0, 2'b10, 0, 32'h110, 16'h0000, 0);
    access(0, 2'b01, 0, 32'h101, 16'h0000, 0);
    access(1, 2'b10, 0, 32'h102, 16'h0000, 32'h1);
    access(0, 2'b11, 0, 32'h100, 16'h0000, 0);
    access(1, 2'b00, 0, 32'h103, 16'h0000, 32'hFF);
    access(0, 2'b00, 0, 32'h103, 16'h0000, 0);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      access(r[0], r[2:1], r[3], 32'h100 + {26'b0, r[9:4]},
             {{12{r[14]}}, r[13:10]}, $urandom);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule